// File: doc/BRIEF.md
# UART Interrupt Status and Mask Controller

This block holds the interrupt state of a UART-style peripheral. An eleven-bit raw status word collects events from the neighbouring receive, transmit, timeout, modem and error logic. An eleven-bit enable mask selects which of those events may reach the interrupt outputs. Software reads and writes both words through a small word-addressed register port. The same port provides a write-one-to-clear register and a transmit-data strobe address.

Six registered, active-high level interrupt lines are driven from the masked status. The combined line is asserted when any enabled source is pending. The other five lines cover receive, transmit, receive timeout, the modem group and the error group. A modem flag update from the line-status logic rebuilds the four modem bits from the current flag levels.

Status bit layout: bits 0..3 modem (0 DSR, 1 DCD, 2 CTS, 3 RI), bit 4 receive, bit 5 transmit, bit 6 receive timeout, bits 7..10 error. Register addresses: 0 mask, 1 raw status, 2 masked status, 3 clear, 4 transmit data.

Top module: `uart_irq_ctrl`

## Requirements
- R1: A read of address 2 returns the raw status AND the enable mask, as held before the read edge.
- R2: A write to address 3 clears every raw status bit whose written data bit is 1 and leaves the others unchanged. A read of address 3 returns zero.
- R3: Writes to address 1 (raw) and address 2 (masked) change neither the raw status nor the mask.
- R4: irq_any_o is the OR of all masked bits. irq_rx_o follows masked bit 4, irq_tx_o bit 5, irq_rt_o bit 6, irq_ms_o the OR of masked bits 0..3, and irq_err_o the OR of masked bits 7..10.
- R5: When modem_upd_i is high, raw bits 0..3 become modem_lvl_i[3:0] exactly. This overrides any set, clear or clear-register write to those bits in the same cycle.
- R6: Any write to address 4 sets raw bit 5 (transmit), whatever the data written.
- R7: Reset clears the mask, the raw status, the read data and all six interrupt lines.
- R8: Interrupt lines and read data are registered. Each reflects the state produced by the clock edge that captures a write, set or update, and so is valid right after that edge.
- R9: A bit with src_set_i high is 1 after the edge, even if a clear-register write in the same cycle targets it.
- R10: A write to address 0 loads data bits 10..0 into the mask. A read of address 0 returns the mask, with bits above 10 reading zero.
- R11: src_clr_i clears raw bits, and src_set_i wins over src_clr_i on the same bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 3 | Word address |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Registered read data |
| src_set_i | input | 11 | Per-bit status set requests |
| src_clr_i | input | 11 | Per-bit status clear requests |
| modem_upd_i | input | 1 | Modem flag update strobe |
| modem_lvl_i | input | 4 | Current modem flags: DSR, DCD, CTS, RI |
| irq_any_o | output | 1 | Combined interrupt |
| irq_rx_o | output | 1 | Receive interrupt |
| irq_tx_o | output | 1 | Transmit interrupt |
| irq_rt_o | output | 1 | Receive timeout interrupt |
| irq_ms_o | output | 1 | Modem status interrupt |
| irq_err_o | output | 1 | Error interrupt |

## Verification
Every result of this block is due exactly one clock edge after its cause. The interrupt lines reflect the status and mask produced by a write, set, clear or modem update at the capturing edge. Read data reflects the state held before that edge. The bench drives each stimulus on a falling edge and updates its model at the following rising edge. It compares the outputs at the next falling edge, with the expected read value taken from the model before the update.

// File: rtl/uimc_pkg.sv
package uimc_pkg;
    localparam int NUM_MODEM = 4;
    localparam int NUM_ERR   = 4;
    localparam int BIT_RX    = NUM_MODEM;
    localparam int BIT_TX    = NUM_MODEM + 1;
    localparam int BIT_RT    = NUM_MODEM + 2;
    localparam int ERR_LO    = NUM_MODEM + 3;
    localparam int STAT_W    = ERR_LO + NUM_ERR;
    localparam int ADDR_W    = 3;
    localparam int NUM_LINES = 6;

    typedef logic [STAT_W-1:0] stat_t;

    typedef enum logic [ADDR_W-1:0] {
        A_MASK   = 3'd0,
        A_RAW    = 3'd1,
        A_MASKED = 3'd2,
        A_CLEAR  = 3'd3,
        A_TXDATA = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic wr_mask;
        logic wr_clear;
        logic wr_tx;
    } wr_dec_t;

    // Source selection for each interrupt line: 0 combined, 1 rx, 2 tx, 3 rt, 4 modem, 5 error
    function automatic stat_t line_sel(input int idx);
        stat_t s;
        s = '0;
        case (idx)
            0: s = '1;
            1: s[BIT_RX] = 1'b1;
            2: s[BIT_TX] = 1'b1;
            3: s[BIT_RT] = 1'b1;
            4: for (int i = 0; i < NUM_MODEM; i++) s[i] = 1'b1;
            default: for (int i = ERR_LO; i < STAT_W; i++) s[i] = 1'b1;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/uimc_decode.sv
module uimc_decode
    import uimc_pkg::*;
(
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output wr_dec_t           dec_o
);
    always_comb begin
        dec_o          = '0;
        dec_o.wr_mask  = wr_i && (addr_i == A_MASK);
        dec_o.wr_clear = wr_i && (addr_i == A_CLEAR);
        dec_o.wr_tx    = wr_i && (addr_i == A_TXDATA);
    end
endmodule

// File: rtl/uimc_status.sv
module uimc_status
    import uimc_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  wr_dec_t              dec_i,
    input  stat_t                wdata_i,
    input  stat_t                set_i,
    input  stat_t                clr_i,
    input  logic                 modem_upd_i,
    input  logic [NUM_MODEM-1:0] modem_lvl_i,
    output stat_t                raw_q_o,
    output stat_t                mask_q_o,
    output stat_t                raw_d_o,
    output stat_t                mask_d_o
);
    typedef struct packed {
        stat_t raw;
        stat_t mask;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        stat_t r;
        stat_t s;
        st_d = st_q;
        if (dec_i.wr_mask) st_d.mask = wdata_i;
        r = st_q.raw;
        if (dec_i.wr_clear) r = r & ~wdata_i;
        r = r & ~clr_i;
        s = set_i;
        if (dec_i.wr_tx) s[BIT_TX] = 1'b1;
        r = r | s;
        if (modem_upd_i) r[NUM_MODEM-1:0] = modem_lvl_i;
        st_d.raw = r;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign raw_q_o  = st_q.raw;
    assign mask_q_o = st_q.mask;
    assign raw_d_o  = st_d.raw;
    assign mask_d_o = st_d.mask;
endmodule

// File: rtl/uimc_irq.sv
module uimc_irq
    import uimc_pkg::*;
(
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  stat_t                raw_d_i,
    input  stat_t                mask_d_i,
    output logic [NUM_LINES-1:0] irq_q_o
);
    logic [NUM_LINES-1:0] irq_d, irq_q;
    stat_t                masked_d;

    assign masked_d = raw_d_i & mask_d_i;

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        assign irq_d[g] = |(masked_d & line_sel(g));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= '0;
        else         irq_q <= irq_d;
    end

    assign irq_q_o = irq_q;
endmodule

// File: rtl/uimc_readback.sv
module uimc_readback
    import uimc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  stat_t             raw_i,
    input  stat_t             mask_i,
    output logic [DATA_W-1:0] rdata_o
);
    logic [DATA_W-1:0] rdata_d, rdata_q;

    always_comb begin
        stat_t v;
        v = '0;
        case (addr_i)
            A_MASK:   v = mask_i;
            A_RAW:    v = raw_i;
            A_MASKED: v = raw_i & mask_i;
            default:  v = '0;
        endcase
        rdata_d = rd_i ? DATA_W'(v) : rdata_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rdata_q <= '0;
        else         rdata_q <= rdata_d;
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
    import uimc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 reg_wr_i,
    input  logic                 reg_rd_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    input  logic [STAT_W-1:0]    src_set_i,
    input  logic [STAT_W-1:0]    src_clr_i,
    input  logic                 modem_upd_i,
    input  logic [NUM_MODEM-1:0] modem_lvl_i,
    output logic                 irq_any_o,
    output logic                 irq_rx_o,
    output logic                 irq_tx_o,
    output logic                 irq_rt_o,
    output logic                 irq_ms_o,
    output logic                 irq_err_o
);
    wr_dec_t              dec;
    stat_t                raw_q, mask_q, raw_d, mask_d;
    logic [NUM_LINES-1:0] irq_q;

    uimc_decode u_dec (
        .wr_i   (reg_wr_i),
        .addr_i (reg_addr_i),
        .dec_o  (dec)
    );

    uimc_status u_stat (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .dec_i       (dec),
        .wdata_i     (reg_wdata_i[STAT_W-1:0]),
        .set_i       (src_set_i),
        .clr_i       (src_clr_i),
        .modem_upd_i (modem_upd_i),
        .modem_lvl_i (modem_lvl_i),
        .raw_q_o     (raw_q),
        .mask_q_o    (mask_q),
        .raw_d_o     (raw_d),
        .mask_d_o    (mask_d)
    );

    uimc_irq u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .raw_d_i  (raw_d),
        .mask_d_i (mask_d),
        .irq_q_o  (irq_q)
    );

    uimc_readback #(.DATA_W(DATA_W)) u_rb (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .rd_i    (reg_rd_i),
        .addr_i  (reg_addr_i),
        .raw_i   (raw_q),
        .mask_i  (mask_q),
        .rdata_o (reg_rdata_o)
    );

    assign irq_any_o = irq_q[0];
    assign irq_rx_o  = irq_q[1];
    assign irq_tx_o  = irq_q[2];
    assign irq_rt_o  = irq_q[3];
    assign irq_ms_o  = irq_q[4];
    assign irq_err_o = irq_q[5];
endmodule

// File: rtl/uimc_checker.sv
module uimc_checker
    import uimc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                 clk_i,
    input logic                 rst_ni,
    input logic                 reg_wr_i,
    input logic                 reg_rd_i,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic [DATA_W-1:0]    reg_wdata_i,
    input logic [DATA_W-1:0]    reg_rdata_o,
    input logic [STAT_W-1:0]    src_set_i,
    input logic [STAT_W-1:0]    src_clr_i,
    input logic                 modem_upd_i,
    input logic [NUM_MODEM-1:0] modem_lvl_i,
    input logic                 irq_any_o,
    input logic                 irq_err_o,
    input stat_t                raw_q,
    input stat_t                mask_q
);
    AST_MASKED_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd_i && reg_addr_i == A_MASKED) |=> reg_rdata_o == DATA_W'($past(raw_q & mask_q))); // R1

    AST_CLEAR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_rd_i && reg_addr_i == A_CLEAR) |=> reg_rdata_o == '0); // R2

    AST_CLEAR_BITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == A_CLEAR && src_set_i == '0 && !modem_upd_i)
        |=> (raw_q & $past(reg_wdata_i[STAT_W-1:0])) == '0); // R2

    AST_RO_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && (reg_addr_i == A_RAW || reg_addr_i == A_MASKED)
         && src_set_i == '0 && src_clr_i == '0 && !modem_upd_i)
        |=> ($stable(raw_q) && $stable(mask_q))); // R3

    AST_COMBINED_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_any_o == (|(raw_q & mask_q))); // R4

    AST_ERR_LINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_err_o == (|(raw_q[STAT_W-1:ERR_LO] & mask_q[STAT_W-1:ERR_LO]))); // R4

    AST_MODEM_REBUILD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        modem_upd_i |=> raw_q[NUM_MODEM-1:0] == $past(modem_lvl_i)); // R5

    AST_TX_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == A_TXDATA) |=> raw_q[BIT_TX]); // R6

    AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (src_set_i[STAT_W-1:NUM_MODEM] != '0)
        |=> ((raw_q[STAT_W-1:NUM_MODEM] & $past(src_set_i[STAT_W-1:NUM_MODEM]))
             == $past(src_set_i[STAT_W-1:NUM_MODEM]))); // R9

    AST_MASK_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (reg_wr_i && reg_addr_i == A_MASK) |=> mask_q == $past(reg_wdata_i[STAT_W-1:0])); // R10
endmodule

bind uart_irq_ctrl uimc_checker #(.DATA_W(DATA_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .src_set_i   (src_set_i),
    .src_clr_i   (src_clr_i),
    .modem_upd_i (modem_upd_i),
    .modem_lvl_i (modem_lvl_i),
    .irq_any_o   (irq_any_o),
    .irq_err_o   (irq_err_o),
    .raw_q       (raw_q),
    .mask_q      (mask_q)
);

// File: tb/sim_uart_irq_ctrl.sv
module sim_uart_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr = 1'b0, rd = 1'b0;
    logic [2:0]    addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic [10:0]   set = '0, clr = '0;
    logic          upd = 1'b0;
    logic [3:0]    lvl = '0;
    logic          i_any, i_rx, i_tx, i_rt, i_ms, i_err;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;

    logic [10:0] m_raw = '0, m_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_irq_ctrl #(.DATA_W(DW)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(wr), .reg_rd_i(rd),
        .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
        .src_set_i(set), .src_clr_i(clr), .modem_upd_i(upd), .modem_lvl_i(lvl),
        .irq_any_o(i_any), .irq_rx_o(i_rx), .irq_tx_o(i_tx), .irq_rt_o(i_rt),
        .irq_ms_o(i_ms), .irq_err_o(i_err)
    );

    function automatic logic [5:0] exp_lines(logic [10:0] r, logic [10:0] m);
        logic [10:0] x;
        x = r & m;
        return {|x[10:7], |x[3:0], x[6], x[5], x[4], |x};
    endfunction

    function automatic logic [31:0] exp_read(logic [2:0] a, logic [10:0] r, logic [10:0] m);
        case (a)
            3'd0: return {21'd0, m};
            3'd1: return {21'd0, r};
            3'd2: return {21'd0, r & m};
            default: return 32'd0;
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive at falling edge, model at rising edge, check at next falling edge
    task automatic step(string req, logic w, logic r, logic [2:0] a, logic [31:0] d,
                        logic [10:0] s, logic [10:0] c, logic u, logic [3:0] l);
        logic [31:0] er;
        logic [10:0] nr;
        wr = w; rd = r; addr = a; wdata = d; set = s; clr = c; upd = u; lvl = l;
        er = exp_read(a, m_raw, m_mask);
        nr = m_raw;
        if (w && a == 3'd3) nr = nr & ~d[10:0];
        nr = nr & ~c;
        nr = nr | s;
        if (w && a == 3'd4) nr[5] = 1'b1;
        if (u) nr[3:0] = l;
        if (w && a == 3'd0) m_mask = d[10:0];
        m_raw = nr;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0; rd = 1'b0; set = '0; clr = '0; upd = 1'b0;
        check({req, " lines R4 R8"}, {26'd0, i_err, i_ms, i_rt, i_tx, i_rx, i_any},
              {26'd0, exp_lines(m_raw, m_mask)});
        if (r) check({req, " read"}, rdata, er);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 reset state
        check("R7 irq", {26'd0, i_err, i_ms, i_rt, i_tx, i_rx, i_any}, 32'd0);
        check("R7 rdata", rdata, 32'd0);
        step("R7 mask", 0, 1, 3'd0, 0, 0, 0, 0, 0);
        step("R7 raw", 0, 1, 3'd1, 0, 0, 0, 0, 0);
        // R10 mask write and read back with upper bits zero
        step("R10 wr", 1, 0, 3'd0, 32'hFFFF_FFFF, 0, 0, 0, 0);
        step("R10 rd", 0, 1, 3'd0, 0, 0, 0, 0, 0);
        // R6 transmit data write sets bit 5
        step("R6", 1, 0, 3'd4, 32'h0, 0, 0, 0, 0);
        step("R6 rd", 0, 1, 3'd1, 0, 0, 0, 0, 0);
        // R3 writes to raw/masked ignored
        step("R3 raw", 1, 0, 3'd1, 32'h7FF, 0, 0, 0, 0);
        step("R3 masked", 1, 0, 3'd2, 32'h000, 0, 0, 0, 0);
        step("R3 rd", 0, 1, 3'd1, 0, 0, 0, 0, 0);
        // R5 modem rebuild, overriding set on same bits
        step("R5", 0, 0, 3'd0, 0, 11'h00F, 0, 1, 4'b1010);
        step("R5 rd", 0, 1, 3'd1, 0, 0, 0, 0, 0);
        step("R5 clr", 0, 0, 3'd0, 0, 0, 0, 1, 4'b0000);
        // R2 clear write and clear read zero
        step("R2 set", 0, 0, 3'd0, 0, 11'h7F0, 0, 0, 0);
        step("R2 clr", 1, 0, 3'd3, 32'h0F0, 0, 0, 0, 0);
        step("R2 rd", 0, 1, 3'd3, 0, 0, 0, 0, 0);
        // R9 set wins over clear write
        step("R9", 1, 0, 3'd3, 32'h7FF, 11'h040, 0, 0, 0);
        step("R9 rd", 0, 1, 3'd1, 0, 0, 0, 0, 0);
        // R11 hardware clear, set wins
        step("R11", 0, 0, 3'd0, 0, 11'h010, 11'h050, 0, 0);
        step("R11 rd", 0, 1, 3'd1, 0, 0, 0, 0, 0);
        // R1 masked read with partial mask
        step("R1 mask", 1, 0, 3'd0, 32'h055, 11'h7FF, 0, 0, 0);
        step("R1 rd", 0, 1, 3'd2, 0, 0, 0, 0, 0);
        // Random mix for R1..R11
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] d;
            logic [2:0]  a;
            logic [10:0] s, c;
            d = $urandom();
            a = 3'($urandom_range(0, 5));
            s = ($urandom_range(0, 3) == 0) ? 11'($urandom()) : 11'd0;
            c = ($urandom_range(0, 3) == 0) ? 11'($urandom()) : 11'd0;
            step("rand R1 R2 R3 R5 R6 R9 R10 R11", 1'($urandom()), 1'($urandom()), a, d, s, c,
                 ($urandom_range(0, 4) == 0), 4'($urandom()));
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule